// File: doc/BRIEF.md
# Amplifier Fault Supervisor

This block watches a two-channel switching amplifier and decides two things every clock: whether the power stage must be parked in high impedance, and whether the open-drain fault line is pulled low. It combines four inputs. The first is the per-channel magnitude and sign of the differential duty deviation. The others are a short-circuit detect pulse, an unsigned die temperature code, and the active-low shutdown input. A power-on reset starts the block from a clean state.

Each fault class has its own state machine and its own release rule. A per-channel persistence machine (`DC_IDLE`, `DC_TIME`, `DC_TRIP`) catches a DC offset that persists too long. `DC_IDLE` moves to `DC_TIME` when the deviation goes above the limit. `DC_TIME` returns to `DC_IDLE` on any break and restarts in place when the polarity flips. It moves to `DC_TRIP` after the persistence window. `DC_TRIP` is left only by power-on reset. The short-circuit machine (`SC_CLEAR`, `SC_LATCHED`) sets on a detect pulse while running and returns to `SC_CLEAR` on any edge that sees shutdown low. Tying the fault line back to the shutdown input therefore gives automatic recovery. The thermal machine (`TH_OK`, `TH_HOT`) trips above 150 and returns below the hysteresis band without outside help. It never touches the fault line. A 4-bit sticky status word records which faults have occurred since power-on.

The persistence window is counted in millisecond ticks derived from the clock frequency parameter. A test build can lower the clock frequency parameter to shorten the window in clock cycles.

Top module: `amp_fault_supervisor`

## Requirements
- R1: After power-on reset with shutdown high and no faults, `hiz` is 0, `fault_n` is 1 and `status` is 0.
- R2: A channel trips when its deviation is strictly greater than DC_LIMIT (14) on HOLD+1 consecutive clock edges with the same sign, where HOLD = DC_MS × (CLK_HZ/TICK_HZ) cycles. A deviation equal to 14 never trips.
- R3: Any edge on which the deviation is at or below the limit restarts the count. A sign change also restarts it, and the first edge at the new sign counts as edge one.
- R4: A DC trip drives `fault_n` low and `hiz` high. It sets status bit 0 for the left channel or bit 1 for the right.
- R5: A DC trip is cleared only by power-on reset. Driving shutdown low and high again leaves `fault_n` low.
- R6: A `short_det` pulse sampled while shutdown is high latches a short fault. From the next edge, `fault_n` is 0, `hiz` is 1 and status bit 2 is set.
- R7: The short latch clears on any edge that samples shutdown low. A `short_det` sampled while shutdown is low is ignored. With `fault_n` fed back to shutdown, the latch releases one cycle after it sets.
- R8: Thermal trips when the temperature code is above 150 and releases when it is at or below 135. While tripped, `hiz` is 1, `fault_n` stays 1 and status bit 3 is set.
- R9: Shutdown low forces `hiz` high at once and restarts both DC persistence counts.
- R10: Status bits are sticky and are cleared only by power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| shdn_n | input | 1 | Shutdown, active low |
| dev_l | input | 7 | Left differential duty deviation, percent |
| pol_l | input | 1 | Left deviation sign, 1 = positive |
| dev_r | input | 7 | Right differential duty deviation, percent |
| pol_r | input | 1 | Right deviation sign, 1 = positive |
| short_det | input | 1 | Short-circuit detect pulse |
| temp_code | input | 8 | Die temperature, unsigned degrees |
| hiz | output | 1 | Force power stage to high impedance |
| fault_n | output | 1 | Fault line, active low |
| status | output | 4 | Sticky faults: bit0 DC left, bit1 DC right, bit2 short, bit3 thermal |

## Verification
A persistence counter that is off by one shows up as `fault_n` falling one cycle early or late. The bench samples on both sides of edge HOLD+1. A counter that misses a sign change or a break trips at the end of a window that should have restarted. A latch that releases on the wrong rule shows up as `fault_n` high after a shutdown pulse, or as `fault_n` still low after a loop-back cycle. The two thermal sweeps catch a wrong hysteresis state on the very code where `hiz` should have changed.

// File: rtl/amp_fault_pkg.sv
package amp_fault_pkg;

    typedef enum logic [1:0] {
        DC_IDLE = 2'd0,
        DC_TIME = 2'd1,
        DC_TRIP = 2'd2
    } dc_state_e;

    typedef enum logic {
        SC_CLEAR   = 1'b0,
        SC_LATCHED = 1'b1
    } sc_state_e;

    typedef enum logic {
        TH_OK  = 1'b0,
        TH_HOT = 1'b1
    } th_state_e;

    localparam int ST_DC_L  = 0;
    localparam int ST_DC_R  = 1;
    localparam int ST_SHORT = 2;
    localparam int ST_THERM = 3;
    localparam int ST_W     = 4;

endpackage

// File: rtl/dc_persist_fsm.sv
module dc_persist_fsm
    import amp_fault_pkg::*;
#(
    parameter int DEV_W    = 7,
    parameter int DC_LIMIT = 14,
    parameter int TICK_DIV = 50000,
    parameter int DC_MS    = 420
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DEV_W-1:0] dev,
    input  logic             pol,
    output logic             tripped
);

    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int MS_W  = $clog2(DC_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [MS_W-1:0]  MS_FULL  = MS_W'(DC_MS);

    dc_state_e        state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic             pol_q;
    logic             above;
    logic             flip;

    assign above = run && (dev > DEV_W'(DC_LIMIT));
    assign flip  = (state_q == DC_TIME) && (pol != pol_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DC_IDLE: if (above) state_d = DC_TIME;
            DC_TIME: begin
                if (!above)                   state_d = DC_IDLE;
                else if (flip)                state_d = DC_TIME;
                else if (ms_q == MS_FULL)     state_d = DC_TRIP;
            end
            DC_TRIP: state_d = DC_TRIP;
            default: state_d = DC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
            pol_q <= 1'b0;
        end else begin
            pol_q <= pol;
            if (!above || state_q == DC_TRIP) begin
                pre_q <= '0;
                ms_q  <= '0;
            end else if (flip) begin
                pre_q <= PRE_W'(1);
                ms_q  <= '0;
            end else if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (ms_q != MS_FULL) ms_q <= ms_q + MS_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    assign tripped = (state_q == DC_TRIP);

    a_r5_dc_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DC_TRIP) |=> (state_q == DC_TRIP));

    a_r3_break_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (!above && state_q != DC_TRIP) |=> (state_q == DC_IDLE));

    a_r2_trip_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DC_TIME && ms_q != MS_FULL) |=> (state_q != DC_TRIP));

endmodule

// File: rtl/short_latch_fsm.sv
module short_latch_fsm
    import amp_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n,
    input  logic short_det,
    output logic latched
);

    sc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_CLEAR:   if (shdn_n && short_det) state_d = SC_LATCHED;
            SC_LATCHED: if (!shdn_n)             state_d = SC_CLEAR;
            default:                             state_d = SC_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SC_CLEAR;
        else        state_q <= state_d;
    end

    assign latched = (state_q == SC_LATCHED);

    a_r7_shdn_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> !latched);

    a_r6_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && short_det) |=> latched);

    a_r7_holds_while_run: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && shdn_n) |=> latched);

endmodule

// File: rtl/thermal_hyst_fsm.sv
module thermal_hyst_fsm
    import amp_fault_pkg::*;
#(
    parameter int TEMP_W  = 8,
    parameter int TRIP_C  = 150,
    parameter int HYST_C  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    output logic              hot
);

    localparam logic [TEMP_W-1:0] TRIP_CODE = TEMP_W'(TRIP_C);
    localparam logic [TEMP_W-1:0] REL_CODE  = TEMP_W'(TRIP_C - HYST_C);

    th_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_OK:  if (temp > TRIP_CODE)  state_d = TH_HOT;
            TH_HOT: if (temp <= REL_CODE)  state_d = TH_OK;
            default:                       state_d = TH_OK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TH_OK;
        else        state_q <= state_d;
    end

    assign hot = (state_q == TH_HOT);

    a_r8_hot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hot && temp > REL_CODE) |=> hot);

    a_r8_cool_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot && temp <= TRIP_CODE) |=> !hot);

endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor
    import amp_fault_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int TICK_HZ  = 1000,
    parameter int DC_MS    = 420,
    parameter int DC_LIMIT = 14,
    parameter int DEV_W    = 7,
    parameter int TEMP_W   = 8,
    parameter int TRIP_C   = 150,
    parameter int HYST_C   = 15
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              shdn_n,
    input  logic [DEV_W-1:0]  dev_l,
    input  logic              pol_l,
    input  logic [DEV_W-1:0]  dev_r,
    input  logic              pol_r,
    input  logic              short_det,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hiz,
    output logic              fault_n,
    output logic [3:0]        status
);

    localparam int TICK_DIV = CLK_HZ / TICK_HZ;
    localparam int N_CH     = 2;

    logic [N_CH-1:0]        dc_trip;
    logic [N_CH-1:0][DEV_W-1:0] ch_dev;
    logic [N_CH-1:0]        ch_pol;
    logic                   sc_lat;
    logic                   th_hot;
    logic [ST_W-1:0]        now_flags;
    logic [ST_W-1:0]        sticky_q;

    assign ch_dev = {dev_r, dev_l};
    assign ch_pol = {pol_r, pol_l};

    for (genvar c = 0; c < N_CH; c++) begin : g_dc
        dc_persist_fsm #(
            .DEV_W   (DEV_W),
            .DC_LIMIT(DC_LIMIT),
            .TICK_DIV(TICK_DIV),
            .DC_MS   (DC_MS)
        ) dc_i (
            .clk    (clk),
            .rst_n  (por_n),
            .run    (shdn_n),
            .dev    (ch_dev[c]),
            .pol    (ch_pol[c]),
            .tripped(dc_trip[c])
        );
    end

    short_latch_fsm sc_i (
        .clk      (clk),
        .rst_n    (por_n),
        .shdn_n   (shdn_n),
        .short_det(short_det),
        .latched  (sc_lat)
    );

    thermal_hyst_fsm #(
        .TEMP_W(TEMP_W),
        .TRIP_C(TRIP_C),
        .HYST_C(HYST_C)
    ) th_i (
        .clk  (clk),
        .rst_n(por_n),
        .temp (temp_code),
        .hot  (th_hot)
    );

    always_comb begin
        now_flags           = '0;
        now_flags[ST_DC_L]  = dc_trip[0];
        now_flags[ST_DC_R]  = dc_trip[1];
        now_flags[ST_SHORT] = sc_lat;
        now_flags[ST_THERM] = th_hot;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sticky_q <= '0;
        else        sticky_q <= sticky_q | now_flags;
    end

    assign status  = sticky_q | now_flags;
    assign fault_n = !(|dc_trip || sc_lat);
    assign hiz     = !shdn_n || |dc_trip || sc_lat || th_hot;

    a_r4_fault_forces_hiz: assert property (@(posedge clk) disable iff (!por_n)
        !fault_n |-> hiz);

    a_r9_shdn_forces_hiz: assert property (@(posedge clk) disable iff (!por_n)
        !shdn_n |-> hiz);

    a_r10_status_sticky: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ((status & $past(status)) == $past(status)));

    a_r8_thermal_not_on_fault: assert property (@(posedge clk) disable iff (!por_n)
        (th_hot && !sc_lat && dc_trip == '0) |-> fault_n);

endmodule

// File: tb/amp_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module amp_fault_supervisor_tb_top;

    localparam int CLK_HZ  = 10_000;
    localparam int TICK_HZ = 1000;
    localparam int DC_MS   = 420;
    localparam int HOLD    = DC_MS * (CLK_HZ / TICK_HZ);

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       shdn_drv = 1'b1;
    logic       loop_en = 1'b0;
    logic [6:0] dev_l = '0;
    logic       pol_l = 1'b0;
    logic [6:0] dev_r = '0;
    logic       pol_r = 1'b0;
    logic       short_det = 1'b0;
    logic [7:0] temp_code = 8'd25;
    logic       hiz;
    logic       fault_n;
    logic [3:0] status;
    logic       shdn_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    assign shdn_n = loop_en ? fault_n : shdn_drv;

    amp_fault_supervisor #(
        .CLK_HZ (CLK_HZ),
        .TICK_HZ(TICK_HZ),
        .DC_MS  (DC_MS)
    ) dut_i (
        .clk      (clk),
        .por_n    (por_n),
        .shdn_n   (shdn_n),
        .dev_l    (dev_l),
        .pol_l    (pol_l),
        .dev_r    (dev_r),
        .pol_r    (pol_r),
        .short_det(short_det),
        .temp_code(temp_code),
        .hiz      (hiz),
        .fault_n  (fault_n),
        .status   (status)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_por();
        por_n = 1'b0;
        dev_l = '0; dev_r = '0; pol_l = 1'b0; pol_r = 1'b0;
        short_det = 1'b0; shdn_drv = 1'b1; loop_en = 1'b0; temp_code = 8'd25;
        step(2);
        por_n = 1'b1;
        step(1);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit hot;
        step(1);
        do_por();
        // R1 reset state
        chk(hiz, 0, "R1 hiz");
        chk(fault_n, 1, "R1 fault_n");
        chk(status, 0, "R1 status");

        // R2 R4 exact trip edge, left channel positive
        dev_l = 7'd20; pol_l = 1'b1;
        step(HOLD);
        chk(fault_n, 1, "R2 no trip at HOLD");
        step(1);
        chk(fault_n, 0, "R2 trip at HOLD+1");
        chk(hiz, 1, "R4 hiz on DC");
        chk(status, 4'b0001, "R4 status left");

        // R5 shutdown pulse does not clear DC
        shdn_drv = 1'b0; step(2); shdn_drv = 1'b1; step(1);
        chk(fault_n, 0, "R5 DC survives shutdown");
        chk(hiz, 1, "R5 hiz stays");

        // R2 threshold sweep
        for (int d = 0; d <= 20; d++) begin
            do_por();
            dev_l = 7'(d); pol_l = 1'b0;
            step(HOLD + 1);
            chk(fault_n, (d > 14) ? 0 : 1, "R2 threshold sweep");
        end

        // R3 one-cycle break restarts
        do_por();
        dev_l = 7'd40; pol_l = 1'b1;
        step(HOLD);
        dev_l = 7'd14; step(1);
        dev_l = 7'd40; step(HOLD);
        chk(fault_n, 1, "R3 break restarts");
        step(1);
        chk(fault_n, 0, "R3 trips after restart");

        // R3 polarity flip restarts
        do_por();
        dev_l = 7'd40; pol_l = 1'b1;
        step(HOLD);
        pol_l = 1'b0; step(HOLD);
        chk(fault_n, 1, "R3 flip restarts");
        step(1);
        chk(fault_n, 0, "R3 trips after flip");

        // R4 right channel
        do_por();
        dev_r = 7'd30; pol_r = 1'b0;
        step(HOLD + 1);
        chk(fault_n, 0, "R4 right trip");
        chk(status, 4'b0010, "R4 status right");

        // R9 shutdown restarts timing and forces hiz
        do_por();
        dev_l = 7'd30; pol_l = 1'b1;
        step(HOLD);
        shdn_drv = 1'b0; step(1);
        chk(hiz, 1, "R9 shutdown hiz");
        chk(fault_n, 1, "R9 shutdown no fault");
        shdn_drv = 1'b1; step(HOLD);
        chk(fault_n, 1, "R9 timer restarted");
        step(1);
        chk(fault_n, 0, "R9 trips after restart");

        // R6 short latch, R7 clear by shutdown
        do_por();
        short_det = 1'b1; step(1); short_det = 1'b0;
        chk(fault_n, 0, "R6 short fault_n");
        chk(hiz, 1, "R6 short hiz");
        chk(status, 4'b0100, "R6 short status");
        step(3);
        chk(fault_n, 0, "R7 latch holds");
        shdn_drv = 1'b0; step(1);
        chk(fault_n, 1, "R7 shutdown clears");
        shdn_drv = 1'b1; step(1);
        chk(hiz, 0, "R7 hiz released");
        chk(status, 4'b0100, "R10 short sticky");

        // R7 short ignored in shutdown
        do_por();
        shdn_drv = 1'b0; short_det = 1'b1; step(1); short_det = 1'b0;
        shdn_drv = 1'b1; step(1);
        chk(fault_n, 1, "R7 ignored in shutdown");
        chk(status, 0, "R7 no status in shutdown");

        // R7 loop-back auto recovery
        do_por();
        loop_en = 1'b1;
        short_det = 1'b1; step(1); short_det = 1'b0;
        chk(fault_n, 0, "R7 loop latched");
        step(1);
        chk(fault_n, 1, "R7 loop recovered");
        chk(hiz, 0, "R7 loop hiz off");
        loop_en = 1'b0;

        // R8 thermal sweeps up and down
        do_por();
        hot = 1'b0;
        for (int t = 0; t <= 200; t++) begin
            temp_code = 8'(t); step(1);
            hot = hot ? (t > 135) : (t > 150);
            chk(hiz, hot, "R8 rising sweep hiz");
            chk(fault_n, 1, "R8 rising fault_n");
        end
        for (int t = 200; t >= 0; t--) begin
            temp_code = 8'(t); step(1);
            hot = hot ? (t > 135) : (t > 150);
            chk(hiz, hot, "R8 falling sweep hiz");
            chk(fault_n, 1, "R8 falling fault_n");
        end
        chk(status, 4'b1000, "R10 thermal sticky");

        // R10 POR clears status
        do_por();
        chk(status, 0, "R10 por clears");

        finish_run();
    end

endmodule